// File: doc/BRIEF.md
# Burst Free Command Decoder

This block turns one buffer-release store into a stream of individual buffer pointers. A store covers between one and sixteen lines. Each line is 16 words of 64 bits. Word 0 of a line is a header that names the pool and carries a flag. The words after it are the buffer pointers being released. The store arrives as a command made of three parts:

- a target address word, which supplies the size of the first line;
- a send-data word, which supplies the line-buffer identifier, the number of lines and the sizes of all later lines;
- a mode bit, which selects a single-line store or a burst.

The decoder reads the line buffer through a read port with combinational data return. That port presents the buffer identifier, a line index and a word index. The decoder then sends each nonzero pointer on a valid/ready stream, together with the pool identifier and flag from the header of its line. The number of pointers in a line is not sent explicitly. It is worked out from a size given in 128-bit units and from an end-of-transfer parity bit in the line header. A new command is refused until every pointer of the current command has been handed off.

Top module: `burst_free_decoder`

## Requirements
- R1: `cmd_ready` is high and `busy` is low exactly when no command is in progress. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` raised while `busy` is high has no effect on the pointer stream. `busy` falls after the last pointer of a command has been handed off.
- R2: In single-line mode (`cmd_burst` = 0), exactly one line (line 0) is processed and `cmd_send[15:12]` is ignored. Line 0 takes its size S from `cmd_tgt_addr[6:4]`.
- R3: The header (word 0) of each line supplies three fields. The pool identifier is bits [19:0]. The end-of-transfer bit E is bit 32. The flag is bit 63. The line then holds 2*S+E pointer words, in words 1 to 2*S+E. All other header bits are ignored.
- R4: Every pointer is sent with `out_pool` and `out_flag` taken from the header of its own line.
- R5: In burst mode, the number of lines is `cmd_send[15:12]`+1. Line 0 takes its size from `cmd_tgt_addr[6:4]`. Line k (k ≥ 1) takes its size from `cmd_send[19+3*(k-1) +: 3]`.
- R6: Lines are processed in ascending order, and pointers within a line in ascending word order.
- R7: A pointer word equal to zero is skipped and never appears on the output.
- R8: A line whose pointer count is zero (S=0, E=0) produces no output, and processing continues with the next line.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_ptr`, `out_pool` and `out_flag` stay unchanged.
- R10: `lb_id` carries `cmd_send[10:0]` of the accepted command for the whole time the command is in progress.
- R11: After reset, the block is idle: `cmd_ready` = 1, `busy` = 0 and `out_valid` = 0. This also holds when reset is asserted in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Decoder can take a command |
| cmd_burst | input | 1 | 1 selects burst mode, 0 selects single-line mode |
| cmd_tgt_addr | input | 64 | Target address word; bits [6:4] give the line-0 size |
| cmd_send | input | 64 | Send-data word: buffer id, line count minus one, later line sizes |
| busy | output | 1 | Command in progress |
| lb_id | output | ID_W | Line-buffer identifier for the read port |
| lb_line | output | log2(MAX_LINES) | Line index being read |
| lb_word | output | log2(LINE_WORDS) | Word index being read |
| lb_rdata | input | 64 | Word returned by the line buffer in the same cycle |
| out_valid | output | 1 | Pointer available |
| out_ready | input | 1 | Consumer takes the pointer |
| out_ptr | output | 64 | Released buffer pointer |
| out_pool | output | POOL_W | Pool identifier of the pointer's line |
| out_flag | output | 1 | Flag from the pointer's line header |

## Verification
Different internal faults show up differently at the ports:

- A wrong latched line size or end-of-transfer bit changes the number of pointers in that line. That in turn changes the count and position of every later beat of the command.
- A wrong line or word counter repeats or drops pointers, or makes `busy` fall early or late. The mismatch shows on the very next handshake, or at the end-of-command count check.
- Stale header registers give a wrong pool or flag on the first pointer of the following line.

The bench compares every handshake against an ordered expected list under several back-pressure patterns. This catches each of these faults within one command.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  localparam int DATA_W       = 64;
  localparam int SIZE_W       = 3;
  localparam int HDR_EOT_BIT  = 32;
  localparam int HDR_FLAG_BIT = 63;
  localparam int SEND_CNT_LSB = 12;
  localparam int SEND_SZ_LSB  = 19;
  localparam int TGT_SZ_LSB   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PTR  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bfd_size_sel.sv
module bfd_size_sel
  import bfd_pkg::*;
#(
  parameter int MAX_LINES = 16,
  localparam int LINE_W = $clog2(MAX_LINES)
) (
  input  logic [SIZE_W-1:0]                 tgt_size,
  input  logic [(MAX_LINES-1)*SIZE_W-1:0]   later_sizes,
  input  logic [LINE_W-1:0]                 line,
  output logic [SIZE_W-1:0]                 size
);
  logic [SIZE_W-1:0] size_tab [MAX_LINES];

  assign size_tab[0] = tgt_size;

  for (genvar k = 1; k < MAX_LINES; k++) begin : g_tab
    assign size_tab[k] = later_sizes[(k-1)*SIZE_W +: SIZE_W];
  end

  assign size = size_tab[line];
endmodule

// File: rtl/bfd_hdr_dec.sv
module bfd_hdr_dec
  import bfd_pkg::*;
#(
  parameter int POOL_W = 20,
  parameter int WIDX_W = 4
) (
  input  logic [DATA_W-1:0]  hdr,
  input  logic [SIZE_W-1:0]  size,
  output logic [POOL_W-1:0]  pool,
  output logic               flag,
  output logic [WIDX_W-1:0]  nptr
);
  assign pool = hdr[POOL_W-1:0];
  assign flag = hdr[HDR_FLAG_BIT];
  // 2*size + eot: the pointer count of the line
  assign nptr = WIDX_W'({size, hdr[HDR_EOT_BIT]});
endmodule

// File: rtl/bfd_seq.sv
module bfd_seq
  import bfd_pkg::*;
#(
  parameter int LINE_W = 4,
  parameter int WIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [LINE_W-1:0] last_line,
  input  logic [WIDX_W-1:0] hdr_nptr,
  input  logic [WIDX_W-1:0] nptr_q,
  input  logic              ptr_zero,
  input  logic              out_ready,
  output seq_state_e        state,
  output logic [LINE_W-1:0] line,
  output logic [WIDX_W-1:0] word,
  output logic              hdr_load
);
  seq_state_e        state_n;
  logic [LINE_W-1:0] line_n;
  logic [WIDX_W-1:0] word_n;
  logic              step_en;

  always_comb begin
    state_n  = state;
    line_n   = line;
    word_n   = word;
    hdr_load = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmd_fire) begin
          state_n = ST_HDR;
          line_n  = '0;
        end
      end
      ST_HDR: begin
        hdr_load = 1'b1;
        if (hdr_nptr == '0) begin
          if (line == last_line) state_n = ST_IDLE;
          else                   line_n  = line + 1'b1;
        end else begin
          state_n = ST_PTR;
          word_n  = WIDX_W'(1);
        end
      end
      ST_PTR: begin
        if (ptr_zero || out_ready) begin
          if (word == nptr_q) begin
            if (line == last_line) begin
              state_n = ST_IDLE;
            end else begin
              state_n = ST_HDR;
              line_n  = line + 1'b1;
            end
          end else begin
            word_n = word + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign step_en = (state != ST_IDLE) || cmd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      line  <= '0;
      word  <= '0;
    end else if (step_en) begin
      state <= state_n;
      line  <= line_n;
      word  <= word_n;
    end
  end
endmodule

// File: rtl/burst_free_decoder.sv
module burst_free_decoder
  import bfd_pkg::*;
#(
  parameter int MAX_LINES  = 16,
  parameter int LINE_WORDS = 16,
  parameter int ID_W       = 11,
  parameter int POOL_W     = 20,
  localparam int LINE_W    = $clog2(MAX_LINES),
  localparam int WIDX_W    = $clog2(LINE_WORDS),
  localparam int LSZ_W     = (MAX_LINES-1)*SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_burst,
  input  logic [63:0]       cmd_tgt_addr,
  input  logic [63:0]       cmd_send,
  output logic              busy,
  output logic [ID_W-1:0]   lb_id,
  output logic [LINE_W-1:0] lb_line,
  output logic [WIDX_W-1:0] lb_word,
  input  logic [63:0]       lb_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_ptr,
  output logic [POOL_W-1:0] out_pool,
  output logic              out_flag
);
  seq_state_e        state;
  logic [LINE_W-1:0] line;
  logic [WIDX_W-1:0] word;
  logic              hdr_load;
  logic              cmd_fire;

  logic [ID_W-1:0]   id_q;
  logic [LINE_W-1:0] last_q;
  logic [SIZE_W-1:0] tsz_q;
  logic [LSZ_W-1:0]  lsz_q;

  logic [SIZE_W-1:0] cur_size;
  logic [POOL_W-1:0] hdr_pool;
  logic              hdr_flag;
  logic [WIDX_W-1:0] hdr_nptr;

  logic [POOL_W-1:0] pool_q;
  logic              flag_q;
  logic [WIDX_W-1:0] nptr_q;
  logic              ptr_zero;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = !cmd_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;

  // command capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      last_q <= '0;
      tsz_q  <= '0;
      lsz_q  <= '0;
    end else if (cmd_fire) begin
      id_q   <= cmd_send[ID_W-1:0];
      last_q <= cmd_burst ? cmd_send[SEND_CNT_LSB +: LINE_W] : '0;
      tsz_q  <= cmd_tgt_addr[TGT_SZ_LSB +: SIZE_W];
      lsz_q  <= cmd_send[SEND_SZ_LSB +: LSZ_W];
    end
  end

  bfd_size_sel #(.MAX_LINES(MAX_LINES)) u_size (
    .tgt_size    (tsz_q),
    .later_sizes (lsz_q),
    .line        (line),
    .size        (cur_size)
  );

  bfd_hdr_dec #(.POOL_W(POOL_W), .WIDX_W(WIDX_W)) u_hdr (
    .hdr  (lb_rdata),
    .size (cur_size),
    .pool (hdr_pool),
    .flag (hdr_flag),
    .nptr (hdr_nptr)
  );

  // header capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_q <= '0;
      flag_q <= 1'b0;
      nptr_q <= '0;
    end else if (hdr_load) begin
      pool_q <= hdr_pool;
      flag_q <= hdr_flag;
      nptr_q <= hdr_nptr;
    end
  end

  assign ptr_zero = (lb_rdata == '0);

  bfd_seq #(.LINE_W(LINE_W), .WIDX_W(WIDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .last_line (last_q),
    .hdr_nptr  (hdr_nptr),
    .nptr_q    (nptr_q),
    .ptr_zero  (ptr_zero),
    .out_ready (out_ready),
    .state     (state),
    .line      (line),
    .word      (word),
    .hdr_load  (hdr_load)
  );

  assign lb_id     = id_q;
  assign lb_line   = line;
  assign lb_word   = (state == ST_PTR) ? word : '0;
  assign out_valid = (state == ST_PTR) && !ptr_zero;
  assign out_ptr   = lb_rdata;
  assign out_pool  = pool_q;
  assign out_flag  = flag_q;
endmodule

// File: rtl/bfd_chk.sv
module bfd_chk #(
  parameter int ID_W   = 11,
  parameter int POOL_W = 20,
  parameter int LINE_W = 4,
  parameter int WIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic [ID_W-1:0]   lb_id,
  input logic [LINE_W-1:0] lb_line,
  input logic [WIDX_W-1:0] lb_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_ptr,
  input logic [POOL_W-1:0] out_pool,
  input logic              out_flag
);
  // R1
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R1
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  // R7
  no_zero_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ptr != 64'd0);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ptr) &&
                                $stable(out_pool) && $stable(out_flag));

  // R10
  id_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(lb_id));

  // R6
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (lb_line != $past(lb_line)) ||
                               (lb_word > $past(lb_word)));
endmodule

bind burst_free_decoder bfd_chk #(
  .ID_W(ID_W), .POOL_W(POOL_W), .LINE_W(LINE_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .lb_id(lb_id), .lb_line(lb_line), .lb_word(lb_word),
  .out_valid(out_valid), .out_ready(out_ready), .out_ptr(out_ptr),
  .out_pool(out_pool), .out_flag(out_flag)
);

// File: tb/burst_free_decoder_test.sv
module burst_free_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_burst, busy;
  logic [63:0] cmd_tgt_addr, cmd_send;
  logic [10:0] lb_id;
  logic [3:0]  lb_line, lb_word;
  logic [63:0] lb_rdata;
  logic        out_valid, out_ready, out_flag;
  logic [63:0] out_ptr;
  logic [19:0] out_pool;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  burst_free_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_burst(cmd_burst), .cmd_tgt_addr(cmd_tgt_addr), .cmd_send(cmd_send),
    .busy(busy), .lb_id(lb_id), .lb_line(lb_line), .lb_word(lb_word),
    .lb_rdata(lb_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_ptr(out_ptr), .out_pool(out_pool), .out_flag(out_flag)
  );

  logic [63:0] mem [16][16];
  assign lb_rdata = mem[lb_line][lb_word];

  typedef struct packed {
    logic        burst;
    logic [2:0]  tsz;
    logic [10:0] id;
    logic [3:0]  cntm1;
    logic [44:0] sizes;
    logic [7:0]  seed;
    logic [7:0]  rpat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 3'd7, 11'h155, 4'd9,  45'o0,               8'h11, 8'hFF},
    '{1'b0, 3'd3, 11'h007, 4'd0,  45'o0,               8'h22, 8'hA5},
    '{1'b1, 3'd2, 11'h7FF, 4'd3,  45'o000000000000702, 8'h33, 8'h6D},
    '{1'b1, 3'd5, 11'h0A0, 4'd15, 45'o765432107654321, 8'h44, 8'hF7},
    '{1'b1, 3'd0, 11'h321, 4'd1,  45'o0,               8'h55, 8'hFF},
    '{1'b1, 3'd7, 11'h1F0, 4'd15, 45'o777777777777777, 8'h66, 8'hC3}
  };

  logic [63:0] exp_ptr  [256];
  logic [19:0] exp_pool [256];
  logic        exp_flag [256];
  int          exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // header: flag bit 63, eot bit 32, junk in [31:20], pool in [19:0]
  task automatic fill(input logic [7:0] seed);
    for (int l = 0; l < 16; l++) begin
      for (int w = 0; w < 16; w++) begin
        if (w == 0)
          mem[l][w] = {seed[l % 8] ^ l[0], 30'h2AAAAAAA, 1'((l + seed) % 2),
                       12'hABC, seed, 8'(l), 4'h5};
        else if (((l * 16 + w + seed) % 7) == 3)
          mem[l][w] = 64'd0;
        else
          mem[l][w] = {seed, 8'(l), 8'(w), 40'hC0FFEE0000 + 40'(l * 16 + w)};
      end
    end
  endtask

  task automatic build_exp(input vec_t v);
    int nl;
    exp_n = 0;
    nl = v.burst ? int'(v.cntm1) + 1 : 1;
    for (int l = 0; l < nl; l++) begin
      int sz, np;
      sz = (l == 0) ? int'(v.tsz) : int'(v.sizes[(l-1)*3 +: 3]);
      np = 2 * sz + int'(mem[l][0][32]);
      for (int w = 1; w <= np; w++) begin
        if (mem[l][w] != 64'd0) begin
          exp_ptr[exp_n]  = mem[l][w];
          exp_pool[exp_n] = mem[l][0][19:0];
          exp_flag[exp_n] = mem[l][0][63];
          exp_n++;
        end
      end
    end
  endtask

  task automatic run(input vec_t v, input bit poke);
    int got, cyc;
    bit held;
    logic [63:0] h_ptr;
    logic [19:0] h_pool;
    logic        h_flag;
    fill(v.seed);
    build_exp(v);
    @(negedge clk);
    check(cmd_ready && !busy, "R1", "ready before command", {cmd_ready, busy}, 2'b10);
    cmd_valid    = 1'b1;
    cmd_burst    = v.burst;
    cmd_tgt_addr = 64'hFFFF_0000_0000_0000 | (64'(v.tsz) << 4) | 64'hF;
    cmd_send     = {v.sizes, 3'b101, v.cntm1, 1'b1, v.id};
    got = 0; cyc = 0; held = 0;
    forever begin
      @(negedge clk);
      cmd_valid = poke && (cyc >= 1) && (cyc <= 3);
      if (poke) begin
        cmd_burst = 1'b0;
        cmd_send  = 64'h0;
      end
      out_ready = v.rpat[cyc % 8];
      #1;
      if (held) begin
        check(out_valid && out_ptr == h_ptr && out_pool == h_pool && out_flag == h_flag,
              "R9", "stall hold", out_ptr, h_ptr);
      end
      held = out_valid && !out_ready;
      h_ptr = out_ptr; h_pool = out_pool; h_flag = out_flag;
      if (out_valid && out_ready) begin
        if (got < exp_n) begin
          check(out_ptr == exp_ptr[got], "R6", "pointer order", out_ptr, exp_ptr[got]);
          check(out_ptr != 64'd0, "R7", "zero skipped", out_ptr, 64'd1);
          check(out_pool == exp_pool[got] && out_flag == exp_flag[got], "R4",
                "pool/flag tag", {out_flag, out_pool}, {exp_flag[got], exp_pool[got]});
          check(lb_id == v.id, "R10", "buffer id", 64'(lb_id), 64'(v.id));
        end
        got++;
      end
      if (!busy) break;
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R1", "command never finished", 64'(cyc), 64'd0);
        break;
      end
    end
    out_ready = 1'b0;
    check(got == exp_n, v.burst ? "R5" : "R2", "pointer count", 64'(got), 64'(exp_n));
    repeat (3) @(negedge clk);
    check(!busy && !out_valid, "R1", "idle after command", {busy, out_valid}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_burst = 1'b0;
    cmd_tgt_addr = '0; cmd_send = '0; out_ready = 1'b0;
    fill(8'h00);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmd_ready && !busy && !out_valid, "R11", "reset state",
          {cmd_ready, busy, out_valid}, 3'b100);
    rst_n = 1'b1;

    foreach (VECS[i]) run(VECS[i], 1'b0);

    // R3 R8: single line, size 0, even seed gives eot 0 on line 0 -> no output
    run('{1'b0, 3'd0, 11'h00F, 4'd0, 45'o0, 8'h02, 8'hFF}, 1'b0);
    // R3: size 0 with eot 1 gives one pointer word
    run('{1'b0, 3'd0, 11'h010, 4'd0, 45'o0, 8'h03, 8'hFF}, 1'b0);
    // R1: a second command offered while busy is ignored
    run(VECS[3], 1'b1);

    // R11: reset in the middle of a command
    fill(8'h44);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_burst = 1'b1;
    cmd_tgt_addr = 64'h70; cmd_send = {45'o777777777777777, 3'b0, 4'd15, 1'b0, 11'h1};
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(busy, "R1", "busy during command", 64'(busy), 64'd1);
    rst_n = 1'b0;
    #1;
    check(cmd_ready && !busy && !out_valid, "R11", "mid-command reset",
          {cmd_ready, busy, out_valid}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule